// File: doc/BRIEF.md
# PC Card Socket Status Monitor

This block watches the status pins of two 16-bit PC Card sockets and turns them into host-readable condition bits, sticky change flags and one interrupt line per socket. Every card pin passes through a two-flop synchronizer first. Card presence is debounced over a host-programmed number of cycles. Each socket is set to either memory or I/O interface mode, and that mode sets what the shared pins mean. In memory mode, the two battery-detect pins are decoded into a three-level health code. In I/O mode, the same pins become a status-change line and a speaker line, and the ready pin becomes an interrupt request.

The host reaches the block through a small write/read register port. Address bit 2 selects the socket (0 or 1), and address bits 1:0 select one of four registers:
- 0: control (bit 0 is the mode, 1 = I/O; bits 7:1 are the debounce count N).
- 1: status (read only).
- 2: change flags (write 1 to clear).
- 3: interrupt enables (bits 3:0).

Reads are combinational. The speaker lines of both sockets are merged onto one output.

Top module: `pccard_status_mon`

## Requirements
- R1: Status bits 2:1 carry the battery code in memory mode: 00 when both battery-detect pins are high, 01 when the first is high and the second low, and 10 whenever the first is low. In I/O mode the field reads 00.
- R2: Status bit 0 (present) can become 1 only when both active-low card-detect pins are low. One low pin alone never counts as a card.
- R3: Presence follows the pins exactly 3+N rising edges after a card-detect change driven between edges. N is control bits 7:1. An excursion that lasts N cycles or fewer is ignored.
- R4: In memory mode, status bit 3 is the ready pin level, bit 4 is the write-protect level, and bit 5 is 0. In I/O mode, bit 3 is 1 when ready is low (interrupt request), bit 4 is 1 when write protect is low (16-bit port), and bit 5 is 1 when the first battery-detect pin is low (status change).
- R5: Flag bit 0 is set on every change of the present bit, in the same cycle as that change.
- R6: While present is 1, memory mode sets flag bit 1 on any ready toggle, bit 2 on any write-protect toggle and bit 3 on any toggle of the first battery-detect pin. I/O mode sets bit 1 only on a falling ready pin and bit 3 only on a falling first battery-detect pin, and never sets bit 2. No bit 1 to 3 is set while present is 0.
- R7: Flags stay set until the host writes 1 to that bit at register 2. If a set event and a clear of the same bit fall in the same cycle, the flag stays set.
- R8: irq of a socket is 1 exactly when some flag bit and its enable bit (register 3, bits 3:0) are both 1.
- R9: The speaker output is the XOR of the per-socket speaker signals. A socket's signal is 1 when it is in I/O mode and its active-low speaker pin is low, and 0 otherwise.
- R10: After reset, control, enables and flags are 0, present is 0, irq and the speaker output are 0, and status reads 8'h18 while the pins idle high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cd1_n | input | 2 | Card-detect 1 per socket, active low |
| cd2_n | input | 2 | Card-detect 2 per socket, active low |
| bvd1 | input | 2 | Battery detect 1 / status-change line per socket |
| bvd2 | input | 2 | Battery detect 2 / speaker line per socket |
| rdy | input | 2 | Ready / interrupt-request line per socket |
| wp | input | 2 | Write protect / 16-bit port line per socket |
| spk_n | input | 2 | Active-low speaker line per socket |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Bit 2 selects the socket, bits 1:0 select the register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| irq | output | 2 | Per-socket interrupt |
| spkr_out | output | 1 | Combined speaker output |

## Verification
A pin toggle can set a change flag in the same cycle that a host write clears flags. The bench provokes this by timing the clear write so that it lands on the third rising edge after a write-protect toggle, the edge on which the synchronized toggle arrives. The bench then reads back the flags. The write-protect flag must survive, while the earlier ready flag cleared by the same write must be gone. Debounced presence and the card flag are also judged together: both must move on the same edge, at exactly 3+N edges.

// File: rtl/pccard_status_mon.sv
module pccard_status_mon (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cd1_n,
  input  logic [1:0] cd2_n,
  input  logic [1:0] bvd1,
  input  logic [1:0] bvd2,
  input  logic [1:0] rdy,
  input  logic [1:0] wp,
  input  logic [1:0] spk_n,
  input  logic       reg_we,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic [1:0] irq,
  output logic       spkr_out
);

  logic [1:0]      det_v, present_v, mode_v, spk_on;
  logic [1:0][3:0] flags_v, en_v;
  logic [1:0][7:0] ctrl_v, stat_v;

  for (genvar s = 0; s < 2; s++) begin : g_sk
    logic [6:0] sy1, sy2;
    logic [7:0] ctrl;
    logic [3:0] en, flags, ev, clr;
    logic [6:0] cnt;
    logic       present, rdy_p, wp_p, b1_p, flip;
    logic [1:0] batt;
    logic       sel, mode;

    assign sel  = reg_addr[2] == 1'(s);
    assign mode = ctrl[0];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        sy1 <= '1;
        sy2 <= '1;
      end else begin
        sy1 <= {spk_n[s], wp[s], rdy[s], bvd2[s], bvd1[s], cd2_n[s], cd1_n[s]};
        sy2 <= sy1;
      end

    assign det_v[s] = ~sy2[0] & ~sy2[1];
    assign flip     = (det_v[s] != present) && (cnt == ctrl[7:1]);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        ctrl <= '0;
        en   <= '0;
      end else if (reg_we && sel) begin
        if (reg_addr[1:0] == 2'd0) ctrl <= reg_wdata;
        if (reg_addr[1:0] == 2'd3) en   <= reg_wdata[3:0];
      end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cnt     <= '0;
        present <= 1'b0;
      end else if (det_v[s] == present) begin
        cnt <= '0;
      end else if (flip) begin
        cnt     <= '0;
        present <= det_v[s];
      end else begin
        cnt <= cnt + 7'd1;
      end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        rdy_p <= 1'b1;
        wp_p  <= 1'b1;
        b1_p  <= 1'b1;
      end else begin
        rdy_p <= sy2[4];
        wp_p  <= sy2[5];
        b1_p  <= sy2[2];
      end

    assign ev[0] = flip;
    assign ev[1] = present & (mode ? (rdy_p & ~sy2[4]) : (rdy_p ^ sy2[4]));
    assign ev[2] = present & ~mode & (wp_p ^ sy2[5]);
    assign ev[3] = present & (mode ? (b1_p & ~sy2[2]) : (b1_p ^ sy2[2]));
    assign clr   = (reg_we && sel && reg_addr[1:0] == 2'd2) ? reg_wdata[3:0] : 4'd0;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) flags <= '0;
      else        flags <= (flags & ~clr) | ev;

    always_comb begin
      if (mode)         batt = 2'b00;
      else if (!sy2[2]) batt = 2'b10;
      else if (!sy2[3]) batt = 2'b01;
      else              batt = 2'b00;
    end

    assign stat_v[s]    = {2'b00, mode & ~sy2[2], mode ^ sy2[5], mode ^ sy2[4], batt, present};
    assign ctrl_v[s]    = ctrl;
    assign flags_v[s]   = flags;
    assign en_v[s]      = en;
    assign present_v[s] = present;
    assign mode_v[s]    = mode;
    assign irq[s]       = |(flags & en);
    assign spk_on[s]    = mode & ~sy2[6];
  end

  assign spkr_out = ^spk_on;

  always_comb
    case (reg_addr[1:0])
      2'd0:    reg_rdata = ctrl_v[reg_addr[2]];
      2'd1:    reg_rdata = stat_v[reg_addr[2]];
      2'd2:    reg_rdata = {4'd0, flags_v[reg_addr[2]]};
      default: reg_rdata = {4'd0, en_v[reg_addr[2]]};
    endcase

endmodule

// File: rtl/pccard_status_mon_chk.sv
module pccard_status_mon_chk (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_we,
  input logic [2:0]      reg_addr,
  input logic [7:0]      reg_wdata,
  input logic [7:0]      reg_rdata,
  input logic [1:0]      irq,
  input logic            spkr_out,
  input logic [1:0]      det_v,
  input logic [1:0]      present_v,
  input logic [1:0]      mode_v,
  input logic [1:0][3:0] flags_v,
  input logic [1:0][3:0] en_v
);

  a_r1_batt_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr[1:0] == 2'd1) |-> (reg_rdata[2:1] != 2'b11));

  a_r9_spk_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_v == 2'b00) |-> !spkr_out);

  for (genvar s = 0; s < 2; s++) begin : g_s
    a_r3_present_follows_det: assert property (@(posedge clk) disable iff (!rst_n)
      $changed(present_v[s]) |-> (present_v[s] == $past(det_v[s])));

    a_r5_card_flag: assert property (@(posedge clk) disable iff (!rst_n)
      $changed(present_v[s]) |-> flags_v[s][0]);

    a_r8_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (en_v[s] == 4'd0) |-> !irq[s]);

    for (genvar b = 0; b < 4; b++) begin : g_b
      a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flags_v[s][b]) |->
          $past(reg_we && reg_addr == 3'(4 * s + 2) && reg_wdata[b]));
    end
  end

endmodule

bind pccard_status_mon pccard_status_mon_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .spkr_out(spkr_out),
  .det_v(det_v), .present_v(present_v), .mode_v(mode_v),
  .flags_v(flags_v), .en_v(en_v)
);

// File: tb/test_pccard_status_mon.sv
module test_pccard_status_mon;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cd1_n = 2'b11, cd2_n = 2'b11, bvd1 = 2'b11, bvd2 = 2'b11;
  logic [1:0] rdy = 2'b11, wp = 2'b11, spk_n = 2'b11;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [1:0] irq;
  logic spkr_out;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  pccard_status_mon i_pccard_status_mon (.*);

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  function automatic logic [7:0] exp_stat(input bit pres, input bit m, input bit b1,
                                          input bit b2, input bit r, input bit w);
    logic [1:0] bt;
    bt = m ? 2'b00 : (!b1 ? 2'b10 : (!b2 ? 2'b01 : 2'b00));
    return {2'b00, m & ~b1, m ^ w, m ^ r, bt, pres};
  endfunction

  function automatic logic [3:0] exp_flags(input bit m, input bit r0, input bit r1,
                                           input bit w0, input bit w1, input bit b0, input bit b1);
    if (m) return {b0 & ~b1, 1'b0, r0 & ~r1, 1'b0};
    return {b0 ^ b1, w0 ^ w1, r0 ^ r1, 1'b0};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [3:0] fl;
    bit m0, m1, r_o, w_o, b_o;
    int unused_seed;
    unused_seed = $urandom(32'd1410);

    #(CLK_P * 3) rst_n = 1'b1;
    // R10 reset state
    rd(3'd0, d); check("R10 ctrl", d, 8'h00);
    rd(3'd1, d); check("R10 status", d, 8'h18);
    rd(3'd2, d); check("R10 flags", d, 8'h00);
    rd(3'd3, d); check("R10 enable", d, 8'h00);
    check("R10 irq", {6'd0, irq}, 8'h00);
    check("R10 spkr", {7'd0, spkr_out}, 8'h00);

    // R2 single detect pin is not a card
    wr(3'd0, 8'h08);
    wr(3'd3, 8'h0F);
    @(negedge clk); cd1_n[0] = 1'b0;
    repeat (20) @(posedge clk);
    rd(3'd1, d); check("R2 one pin low", {7'd0, d[0]}, 8'h00);
    cd1_n[0] = 1'b1;
    repeat (10) @(posedge clk);

    // R3 debounce exact timing with N=4, R5 card flag
    @(negedge clk); cd1_n[0] = 1'b0; cd2_n[0] = 1'b0; reg_addr = 3'd1;
    repeat (6) @(posedge clk);
    @(negedge clk); check("R3 not yet present", {7'd0, reg_rdata[0]}, 8'h00);
    @(posedge clk);
    @(negedge clk); check("R3 present at 3+N", {7'd0, reg_rdata[0]}, 8'h01);
    rd(3'd2, d); check("R5 insert flag", d, 8'h01);
    check("R8 irq on", {6'd0, irq}, 8'h01);
    wr(3'd2, 8'h01);
    rd(3'd2, d); check("R7 w1c clears", d, 8'h00);
    check("R8 irq off", {6'd0, irq}, 8'h00);

    // R3 glitch of N cycles is ignored
    @(negedge clk); cd2_n[0] = 1'b1;
    repeat (4) @(negedge clk);
    cd2_n[0] = 1'b0;
    repeat (12) @(posedge clk);
    rd(3'd1, d); check("R3 glitch present", {7'd0, d[0]}, 8'h01);
    rd(3'd2, d); check("R3 glitch no flag", d, 8'h00);

    // random patterns: R1 R4 R6 R9
    for (int i = 0; i < 60; i++) begin
      m0 = 1'($urandom); m1 = 1'($urandom);
      wr(3'd0, {7'd4, m0});
      wr(3'd4, {7'd4, m1});
      wr(3'd2, 8'h0F);
      wr(3'd6, 8'h0F);
      r_o = rdy[0]; w_o = wp[0]; b_o = bvd1[0];
      @(negedge clk);
      rdy = 2'($urandom); wp = 2'($urandom); bvd1 = 2'($urandom);
      bvd2 = 2'($urandom); spk_n = 2'($urandom);
      repeat (5) @(posedge clk);
      rd(3'd1, d);
      check(m0 ? "R4 io status" : "R1 R4 mem status", d,
            exp_stat(1'b1, m0, bvd1[0], bvd2[0], rdy[0], wp[0]));
      rd(3'd2, d);
      fl = exp_flags(m0, r_o, rdy[0], w_o, wp[0], b_o, bvd1[0]);
      check("R6 flags", d, {4'd0, fl});
      check("R8 irq", {7'd0, irq[0]}, {7'd0, |fl});
      rd(3'd6, d); check("R6 absent no flags", d, 8'h00);
      check("R9 speaker", {7'd0, spkr_out},
            {7'd0, (m0 & ~spk_n[0]) ^ (m1 & ~spk_n[1])});
    end

    // R7 set and clear in the same cycle: set wins
    wr(3'd0, 8'h08);
    wr(3'd4, 8'h08);
    @(negedge clk); rdy[0] = 1'b1; wp[0] = 1'b0; bvd1[0] = 1'b1;
    repeat (6) @(posedge clk);
    wr(3'd2, 8'h0F);
    @(negedge clk); rdy[0] = 1'b0;
    repeat (6) @(posedge clk);
    rd(3'd2, d); check("R6 ready toggle", d, 8'h02);
    @(negedge clk); wp[0] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); reg_we = 1'b1; reg_addr = 3'd2; reg_wdata = 8'h0F;
    @(posedge clk);
    @(negedge clk); reg_we = 1'b0;
    rd(3'd2, d); check("R7 set beats clear", d, 8'h04);

    // R8 masking
    wr(3'd3, 8'h0B);
    check("R8 masked irq", {7'd0, irq[0]}, 8'h00);
    wr(3'd3, 8'h04);
    check("R8 enabled irq", {7'd0, irq[0]}, 8'h01);
    wr(3'd2, 8'h0F);

    // R5 removal
    @(negedge clk); cd1_n[0] = 1'b1;
    repeat (12) @(posedge clk);
    rd(3'd1, d); check("R5 removed", {7'd0, d[0]}, 8'h00);
    rd(3'd2, d); check("R5 removal flag", {7'd0, d[0]}, 8'h01);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule